// File: doc/BRIEF.md
# Masked-Snapshot Latched Status Register Bank

This block holds four 8-bit status registers for a line-interface controller. Each bit records an event or alarm from a synchronous event input and keeps it until software collects it. Two of the registers also drive active-low interrupt outputs, and each of their bits can be masked by an interrupt enable register.

Software collects status in two steps. It first writes a selection byte to a status address. For each bit selected with a 1, the readable copy (the snapshot) takes the bit's current latched value and the latch is cleared. Each unselected bit keeps its old snapshot value, and its latch is not touched. Software then reads the snapshot. It can write the value it read, ANDed with its selection, back to the same address. That second write clears any bit that an event set again between the two accesses. Because of this scheme, software can poll single bits without disturbing the other bits in the same register.

Address map:

- Status registers: 0, 1, 2 and 3.
- Interrupt masks for registers 0 and 1: addresses 4 and 5.
- Addresses 6 and 7 read as 0.

Top module: `latch_status_bank`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are high.
- R2: A 1 on any event input bit sets the matching latch at the next clock edge. The latch stays set after the input returns to 0.
- R3: A write to status address k with data bit j = 1 has two effects at that edge. Snapshot bit j takes latch bit j, and latch bit j is cleared.
- R4: A data bit of 0 in a status write leaves that snapshot bit and that latch bit unchanged. Reads of addresses 0 to 3 return the snapshot.
- R5: If an event bit is 1 in the same cycle as a clearing write, the latch stays set. The snapshot still takes the value the latch held before that edge.
- R6: While an alarm input is held at 1, its latch sets again at once after each clear. Every snapshot taken during the alarm reads 1.
- R7: `irq_stat0_n` is 0 exactly while some latch bit of register 0 is set and the same bit of mask address 4 is 1.
- R8: `irq_stat1_n` follows the rule of R7 for register 1 and mask address 5. Registers 2 and 3 never affect either interrupt output.
- R9: Addresses 4 and 5 are plain read/write mask registers. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data or selection byte |
| bus_rdata | output | 8 | Read data, combinational from the address |
| evt_stat0 | input | 8 | Event inputs of status register 0 |
| evt_stat1 | input | 8 | Event inputs of status register 1 |
| evt_stat2 | input | 8 | Event inputs of status register 2 |
| evt_stat3 | input | 8 | Event inputs of status register 3 |
| irq_stat0_n | output | 1 | Active-low interrupt for register 0 |
| irq_stat1_n | output | 1 | Active-low interrupt for register 1 |

## Verification
An event can arrive in the same cycle as a selection write that clears its latch. The bench provokes this by driving the event input and the write strobe on the same falling edge. It then judges three things: the snapshot must show the old value, the latch must survive, and the interrupt must stay low. A later snapshot must then show the bit. Held alarms provoke the same collision on every cycle. For those, every snapshot must read 1 until the input drops.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int DW    = 8;
  localparam int NREG  = 4;
  localparam int NIRQ  = 2;
  localparam int AW    = 3;
  localparam int IMR_BASE = NREG;

  // selection applied to status register idx by a write
  function automatic logic [DW-1:0] sel_for(input logic wr, input logic [AW-1:0] addr,
                                           input int idx, input logic [DW-1:0] wdata);
    return (wr && (int'(addr) == idx)) ? wdata : '0;
  endfunction

  // latch update: selected bits clear, events always win
  function automatic logic [DW-1:0] latch_next(input logic [DW-1:0] lat,
                                              input logic [DW-1:0] evt,
                                              input logic [DW-1:0] sel);
    return (lat & ~sel) | evt;
  endfunction

  // snapshot update: selected bits copy the latch
  function automatic logic [DW-1:0] snap_next(input logic [DW-1:0] shw,
                                             input logic [DW-1:0] lat,
                                             input logic [DW-1:0] sel);
    return (shw & ~sel) | (lat & sel);
  endfunction

  function automatic logic irq_level_n(input logic [DW-1:0] lat, input logic [DW-1:0] msk);
    return ~|(lat & msk);
  endfunction
endpackage

// File: rtl/lsb_cell.sv
module lsb_cell
  import lsb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sel,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] lat_q,
  output logic [DW-1:0] shw_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      shw_q <= '0;
    end else begin
      lat_q <= latch_next(lat_q, evt, sel);
      shw_q <= snap_next(shw_q, lat_q, sel);
    end
  end
endmodule

// File: rtl/lsb_irq.sv
module lsb_irq
  import lsb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] lat,
  output logic [DW-1:0] msk_q,
  output logic          irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     msk_q <= '0;
    else if (wr_en) msk_q <= wdata;
  end
  assign irq_n = irq_level_n(lat, msk_q);
endmodule

// File: rtl/latch_status_bank.sv
module latch_status_bank
  import lsb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [7:0]    evt_stat0,
  input  logic [7:0]    evt_stat1,
  input  logic [7:0]    evt_stat2,
  input  logic [7:0]    evt_stat3,
  output logic          irq_stat0_n,
  output logic          irq_stat1_n
);
  // named internal buses, also observed by the checker
  logic [NREG*DW-1:0] ev_all;
  logic [NREG*DW-1:0] lat_all;
  logic [NREG*DW-1:0] shw_all;
  logic [NIRQ*DW-1:0] msk_all;
  logic [NIRQ-1:0]    irq_all_n;

  assign ev_all = {evt_stat3, evt_stat2, evt_stat1, evt_stat0};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] sel;
    assign sel = sel_for(bus_wr, bus_addr, g, bus_wdata);
    lsb_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .evt   (ev_all[g*DW +: DW]),
      .lat_q (lat_all[g*DW +: DW]),
      .shw_q (shw_all[g*DW +: DW])
    );
  end

  for (genvar g = 0; g < NIRQ; g++) begin : g_irq
    logic wr_en;
    assign wr_en = bus_wr && (int'(bus_addr) == IMR_BASE + g);
    lsb_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wdata (bus_wdata),
      .lat   (lat_all[g*DW +: DW]),
      .msk_q (msk_all[g*DW +: DW]),
      .irq_n (irq_all_n[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) < NREG)
      bus_rdata = shw_all[bus_addr[1:0]*DW +: DW];
    else if (int'(bus_addr) < NREG + NIRQ)
      bus_rdata = msk_all[(int'(bus_addr) - NREG)*DW +: DW];
  end

  assign irq_stat0_n = irq_all_n[0];
  assign irq_stat1_n = irq_all_n[1];
endmodule

// File: rtl/lsb_chk.sv
module lsb_chk
  import lsb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [2:0]         bus_addr,
  input logic [7:0]         bus_wdata,
  input logic [NREG*DW-1:0] ev_all,
  input logic [NREG*DW-1:0] lat_all,
  input logic [NREG*DW-1:0] shw_all,
  input logic [NIRQ*DW-1:0] msk_all,
  input logic               irq_stat0_n,
  input logic               irq_stat1_n
);
  p_event_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_all != '0) |=> ((lat_all & $past(ev_all)) == $past(ev_all)));

  p_selected_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && ev_all[7:0] == '0) |=> ((lat_all[7:0] & $past(bus_wdata)) == '0));

  p_idle_snapshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr) |=> $stable(shw_all));

  p_collision_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1 && ev_all[15:8] != '0) |=> ((lat_all[15:8] & $past(ev_all[15:8])) != '0));

  p_irq0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat0_n == 1'b0) |-> ((lat_all[7:0] & msk_all[7:0]) != '0));

  p_irq1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat1_n == 1'b1) |-> ((lat_all[15:8] & msk_all[15:8]) == '0));
endmodule

bind latch_status_bank lsb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .ev_all     (ev_all),
  .lat_all    (lat_all),
  .shw_all    (shw_all),
  .msk_all    (msk_all),
  .irq_stat0_n(irq_stat0_n),
  .irq_stat1_n(irq_stat1_n)
);

// File: tb/test_latch_status_bank.sv
module test_latch_status_bank;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] ev0 = 0, ev1 = 0, ev2 = 0, ev3 = 0;
  logic       irq0_n, irq1_n;

  always #10 clk = ~clk;

  latch_status_bank i_latch_status_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_stat0(ev0), .evt_stat1(ev1), .evt_stat2(ev2), .evt_stat3(ev3),
    .irq_stat0_n(irq0_n), .irq_stat1_n(irq1_n)
  );

  typedef struct { string req; string what; int val; } item_t;
  item_t exp_q[$];
  item_t obs_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // monitor: pops matched pairs and compares
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        item_t e, o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        n_cmp++;
        if (e.val != o.val) begin
          n_bad++;
          $display("FAIL %s %s: actual %0h expected %0h", e.req, e.what, o.val, e.val);
        end
      end
    end
  end

  task automatic push(string req, string what, int expv, int actv);
    item_t e, o;
    e.req = req; e.what = what; e.val = expv;
    o.req = req; o.what = what; o.val = actv;
    exp_q.push_back(e);
    obs_q.push_back(o);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] expv, string req);
    bus_addr = a;
    #1;
    push(req, $sformatf("read addr %0d", a), expv, bus_rdata);
  endtask

  task automatic irq(input logic e0, input logic e1, string req);
    #1;
    push(req, "irq0_n", e0, irq0_n);
    push(req, "irq1_n", e1, irq1_n);
  endtask

  task automatic pulse(input int r, input logic [7:0] b);
    @(negedge clk);
    case (r) 0: ev0 = b; 1: ev1 = b; 2: ev2 = b; default: ev3 = b; endcase
    @(negedge clk);
    case (r) 0: ev0 = 0; 1: ev1 = 0; 2: ev2 = 0; default: ev3 = 0; endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1");
    irq(1, 1, "R1");

    // R2 latch holds after pulse; R7 masked interrupt stays high
    pulse(0, 8'h05);
    @(negedge clk);
    irq(1, 1, "R7");
    wr(3'd4, 8'h04);
    rd(3'd4, 8'h04, "R9");
    irq(0, 1, "R7");
    // R3 select bit0 only
    wr(3'd0, 8'h01);
    rd(3'd0, 8'h01, "R3");
    irq(0, 1, "R2");
    // R4 bit0 kept, bit2 collected
    wr(3'd0, 8'h04);
    rd(3'd0, 8'h05, "R4");
    irq(1, 1, "R7");
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h00, "R3");

    // R4 untouched latch survives partial snapshot
    pulse(1, 8'h03);
    wr(3'd1, 8'h01);
    rd(3'd1, 8'h01, "R4");
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h03, "R4");
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h00, "R3");

    // R5 event concurrent with clearing write
    wr(3'd5, 8'h10);
    rd(3'd5, 8'h10, "R9");
    @(negedge clk);
    bus_wr = 1; bus_addr = 3'd1; bus_wdata = 8'h10; ev1 = 8'h10;
    @(negedge clk);
    bus_wr = 0; ev1 = 0;
    rd(3'd1, 8'h00, "R5");
    irq(1, 0, "R5");
    wr(3'd1, 8'h10);
    rd(3'd1, 8'h10, "R5");
    irq(1, 1, "R8");

    // R6 persistent alarm
    @(negedge clk); ev2 = 8'h80;
    @(negedge clk);
    wr(3'd2, 8'h80);
    rd(3'd2, 8'h80, "R6");
    wr(3'd2, 8'h80);
    rd(3'd2, 8'h80, "R6");
    ev2 = 0;
    wr(3'd2, 8'h80);
    rd(3'd2, 8'h80, "R6");
    wr(3'd2, 8'h80);
    rd(3'd2, 8'h00, "R6");

    // R8 info registers never raise interrupts
    wr(3'd4, 8'hFF);
    wr(3'd5, 8'hFF);
    pulse(3, 8'hFF);
    pulse(2, 8'h3C);
    @(negedge clk);
    irq(1, 1, "R8");
    wr(3'd3, 8'hFF);
    rd(3'd3, 8'hFF, "R2");
    wr(3'd2, 8'hFF);
    rd(3'd2, 8'h3C, "R2");

    // R9 unmapped and mask readback
    rd(3'd6, 8'h00, "R9");
    rd(3'd7, 8'h00, "R9");
    rd(3'd5, 8'hFF, "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule